// File: doc/BRIEF.md
# Falling-Edge NMI Trap Controller

This block turns an asynchronous, active-low external trap pin into a one-cycle non-maskable request for the CPU. The pin is brought into the clock domain through a chain of flip-flops, and a further registered stage compares consecutive samples to find high-to-low transitions. A transition counts as a trap event only while the block is armed. Each trap event raises the request for one cycle and sets a sticky flag in a byte-wide status register.

Software arms the block in one of two ways. The one-shot arm bit disarms itself on the first trap event it lets through. The lock bit keeps the block armed until reset, and no write can clear it. The status byte is read-only, and the flag clears when it is read. The read returns the value held before the clear. All pins are plain control and status signals: the status read is a single-cycle strobe with data returned in the same cycle, so there is no stream interface and no back-pressure.

Top module: `nmi_trap_ctl`

## Requirements
- R1: After reset the status byte is 0x00, the request output is low, and both the one-shot arm state and the lock state are 0.
- R2: When the block is armed, a high-to-low transition on `trap_pin_n` raises `nmi_req` for exactly one cycle. The request appears SYNC_STAGES+1 rising clock edges after the new pin level is first sampled.
- R3: A low-to-high transition on `trap_pin_n` never raises `nmi_req`.
- R4: While neither the arm state nor the lock state is set, falling edges are ignored: `nmi_req` stays low and status bit 0 stays 0.
- R5: A write with `ctl_wr`=1 and `ctl_arm`=1 sets the one-shot arm state. The first trap event clears it, and a later falling edge raises no request unless the block is locked. A write with `ctl_arm`=0 clears the one-shot arm state.
- R6: A write with `ctl_wr`=1 and `ctl_lock`=1 sets the lock state. The lock state stays set through trap events and through writes with `ctl_lock`=0, and only reset clears it. Every falling edge raises a request while the block is locked.
- R7: Bit 0 of `stat_q` is the trap-event flag, and a trap event sets it. Bits 7:1 always read 0.
- R8: `stat_q` shows the status in the same cycle `stat_rd` is high, and the flag is cleared at the end of that cycle.
- R9: If a trap event and a status read fall in the same cycle, the flag is left set.
- R10: If a trap event and an arm write fall in the same cycle, the event wins: the one-shot arm state ends up 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_pin_n | input | 1 | Asynchronous trap pin, falling edge active |
| ctl_wr | input | 1 | Control write strobe |
| ctl_arm | input | 1 | Value written to the one-shot arm state |
| ctl_lock | input | 1 | Writing 1 sets the lock state; 0 has no effect |
| stat_rd | input | 1 | Status read strobe |
| stat_q | output | STAT_W | Status byte, bit 0 = trap event |
| arm_q | output | 1 | One-shot arm state |
| lock_q | output | 1 | Lock state |
| nmi_req | output | 1 | One-cycle non-maskable request |

## Verification
The bench builds the block with SYNC_STAGES=2 and STAT_W=8. From these values it computes a three-edge latency on its own side. With that latency known, the bench can land a status read or an arm write exactly on the cycle in which a trap event completes, which is needed to exercise the R9 and R10 collisions. The 8-bit status width lets the bench check that the reserved bits read as zero across the whole byte.

// File: rtl/nmi_trap_pkg.sv
package nmi_trap_pkg;
  // Position of the trap-event flag inside the status byte
  localparam int unsigned TRAP_FLAG_BIT = 0;

  typedef struct packed {
    logic armed;
    logic locked;
  } arm_state_t;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  // Idle level of the pin is high, so the chain resets to 1
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/nmi_fall_det.sv
module nmi_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level_i;
  end

  assign fall_o = prev_q & ~level_i;
endmodule

// File: rtl/nmi_arm_ctl.sv
module nmi_arm_ctl
  import nmi_trap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic       arm_i,
  input  logic       lock_i,
  input  logic       event_i,
  output arm_state_t state_o
);
  arm_state_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      // One-shot arm: a trap event takes precedence over a write
      if (event_i)   st_q.armed <= 1'b0;
      else if (wr_i) st_q.armed <= arm_i;
      // Lock: set-only until reset
      if (wr_i && lock_i) st_q.locked <= 1'b1;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/nmi_stat_reg.sv
module nmi_stat_reg
  import nmi_trap_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] stat_o
);
  logic flag_q;

  // A new event beats the read clear so it is never lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (rd_i)  flag_q <= 1'b0;
  end

  always_comb begin
    stat_o = '0;
    stat_o[TRAP_FLAG_BIT] = flag_q;
  end
endmodule

// File: rtl/nmi_trap_ctl.sv
module nmi_trap_ctl
  import nmi_trap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STAT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_pin_n,
  input  logic              ctl_wr,
  input  logic              ctl_arm,
  input  logic              ctl_lock,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_q,
  output logic              arm_q,
  output logic              lock_q,
  output logic              nmi_req
);
  logic       pin_sync;
  logic       fall;
  logic       trap_evt;
  arm_state_t st;

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(trap_pin_n), .sync_o(pin_sync)
  );

  nmi_fall_det u_fall (
    .clk(clk), .rst_n(rst_n), .level_i(pin_sync), .fall_o(fall)
  );

  assign trap_evt = fall & (st.armed | st.locked);

  nmi_arm_ctl u_arm (
    .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr), .arm_i(ctl_arm),
    .lock_i(ctl_lock), .event_i(trap_evt), .state_o(st)
  );

  nmi_stat_reg #(.WIDTH(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(trap_evt), .rd_i(stat_rd), .stat_o(stat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_req <= 1'b0;
    else        nmi_req <= trap_evt;
  end

  assign arm_q  = st.armed;
  assign lock_q = st.locked;
endmodule

// File: rtl/nmi_trap_chk.sv
module nmi_trap_chk #(
  parameter int unsigned STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stat_rd,
  input logic [STAT_W-1:0] stat_q,
  input logic              arm_q,
  input logic              lock_q,
  input logic              nmi_req
);
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);                                        // R2
  AST_REQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> $past(arm_q | lock_q));                           // R4
  AST_ONESHOT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !lock_q) |-> !arm_q);                             // R5
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);                                           // R6
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[STAT_W-1:1] == '0);                                    // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_rd) && !nmi_req) |-> !stat_q[0]);                 // R8
  AST_EVENT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> stat_q[0]);                                       // R9
endmodule

bind nmi_trap_ctl nmi_trap_chk #(.STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .stat_q(stat_q),
  .arm_q(arm_q), .lock_q(lock_q), .nmi_req(nmi_req)
);

// File: tb/sim_nmi_trap_ctl.sv
module sim_nmi_trap_ctl;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned SYNC = 2;
  localparam int unsigned SW   = 8;
  localparam int unsigned LAT  = SYNC + 1;

  // Operations; the observed value for each:
  // ARM/DISARM/LOCK/PEEK -> {6'b0, arm, lock}
  // FALL -> {requests after rise[3:0], requests after fall[3:0]}
  // READ -> status byte
  localparam logic [2:0] OP_ARM = 3'd0, OP_DISARM = 3'd1, OP_LOCK = 3'd2,
                         OP_FALL = 3'd3, OP_READ = 3'd4, OP_PEEK = 3'd5;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{OP_READ,   8'h00, 4'd1},  // R1
    '{OP_FALL,   8'h00, 4'd4},  // R4 disabled edge ignored
    '{OP_READ,   8'h00, 4'd4},  // R4 flag untouched
    '{OP_ARM,    8'h02, 4'd5},  // R5 arm set
    '{OP_FALL,   8'h01, 4'd2},  // R2 one request, R3 none on rise
    '{OP_PEEK,   8'h00, 4'd5},  // R5 one-shot cleared
    '{OP_READ,   8'h01, 4'd7},  // R7 flag at bit 0
    '{OP_READ,   8'h00, 4'd8},  // R8 cleared by read
    '{OP_FALL,   8'h00, 4'd5},  // R5 disarmed after event
    '{OP_ARM,    8'h02, 4'd5},  // R5
    '{OP_DISARM, 8'h00, 4'd5},  // R5 write 0 disarms
    '{OP_FALL,   8'h00, 4'd5},  // R5
    '{OP_LOCK,   8'h01, 4'd6},  // R6
    '{OP_FALL,   8'h01, 4'd6},  // R6
    '{OP_FALL,   8'h01, 4'd6},  // R6 still armed
    '{OP_DISARM, 8'h01, 4'd6},  // R6 lock survives write 0
    '{OP_READ,   8'h01, 4'd7},  // R7
    '{OP_FALL,   8'h01, 4'd3}   // R3 rise gives nothing
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_pin_n = 1'b1;
  logic ctl_wr = 1'b0, ctl_arm = 1'b0, ctl_lock = 1'b0, stat_rd = 1'b0;
  logic [SW-1:0] stat_q;
  logic arm_q, lock_q, nmi_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_trap_ctl #(.SYNC_STAGES(SYNC), .STAT_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .trap_pin_n(trap_pin_n), .ctl_wr(ctl_wr),
    .ctl_arm(ctl_arm), .ctl_lock(ctl_lock), .stat_rd(stat_rd),
    .stat_q(stat_q), .arm_q(arm_q), .lock_q(lock_q), .nmi_req(nmi_req)
  );

  task automatic check(input int r, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_op(input logic [2:0] op, output logic [7:0] obs);
    logic [3:0] cf, cr;
    cf = '0; cr = '0;
    obs = '0;
    case (op)
      OP_ARM, OP_DISARM, OP_LOCK: begin
        ctl_wr = 1'b1; ctl_arm = (op == OP_ARM); ctl_lock = (op == OP_LOCK);
        @(negedge clk);
        ctl_wr = 1'b0; ctl_arm = 1'b0; ctl_lock = 1'b0;
        obs = {6'b0, arm_q, lock_q};
      end
      OP_FALL: begin
        trap_pin_n = 1'b0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); cf += 4'(nmi_req); end
        trap_pin_n = 1'b1;
        for (int i = 0; i < 6; i++) begin @(negedge clk); cr += 4'(nmi_req); end
        obs = {cr, cf};
      end
      OP_READ: begin
        stat_rd = 1'b1;
        #1 obs = stat_q;
        @(negedge clk);
        stat_rd = 1'b0;
      end
      default: obs = {6'b0, arm_q, lock_q};
    endcase
  endtask

  initial begin
    logic [7:0] obs;
    int reqs;
    do_reset();
    // R1 reset state at the ports
    check(1, stat_q, 8'h00);
    check(1, {6'b0, arm_q, lock_q}, 8'h00);
    check(1, {7'b0, nmi_req}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      do_op(VECS[v].op, obs);
      check(int'(VECS[v].req), obs, VECS[v].exp);
    end

    // R9: read lands on the cycle the trap event completes (lock still set, flag set)
    do_op(OP_FALL, obs);
    trap_pin_n = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check(9, {7'b0, nmi_req}, 8'h01);
    check(9, stat_q, 8'h01);
    trap_pin_n = 1'b1;
    repeat (6) @(negedge clk);

    // R10: arm write collides with the event; event wins
    do_reset();
    check(1, {6'b0, arm_q, lock_q}, 8'h00);  // R1 after second reset
    do_op(OP_ARM, obs);
    check(10, obs, 8'h02);
    trap_pin_n = 1'b0;
    reqs = 0;
    repeat (LAT - 1) @(negedge clk);
    ctl_wr = 1'b1; ctl_arm = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_arm = 1'b0;
    reqs += int'(nmi_req);
    check(10, {6'b0, arm_q, lock_q}, 8'h00);
    check(10, 8'(reqs), 8'h01);
    trap_pin_n = 1'b1;
    repeat (6) @(negedge clk);
    // R5 after the collision the block stays disarmed
    do_op(OP_FALL, obs);
    check(5, obs, 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule